// File: doc/BRIEF.md
# Flash Embedded-Operation Status Generator

This block models the device side of a parallel NOR flash while an embedded program or erase runs. It takes single-cycle command pulses for program, sector erase, chip erase, erase suspend, erase resume and reset, together with an address and a data byte. It tracks the operation state, which sectors are marked for erase, a program pulse counter and a sector-erase acceptance window.

A read strobe returns a byte one cycle later. The byte is either status or array data. When no operation is running, reads return the contents of a small internal byte array. That array stands in for the flash cells: a program can only clear bits, and an erase sets whole sectors back to 0xFF.

While an operation is running, reads return a status byte. It carries two toggle bits with different meanings, a timeout flag and an erase-started flag. Host software combines these to tell whether the device is busy, erasing or suspended, which sectors are affected, and whether the operation failed.

Top module: `flash_status_gen`

## Requirements
- R1: Status bit 6 inverts on every read while the device is busy: programming, inside the erase window, erasing, programming during suspend, or halted on a fault. This holds for any read address.
- R2: Status bit 2 inverts on each read whose address lies in a sector marked for erase. A read outside the marked sectors leaves it unchanged.
- R3: During erase suspend, bit 6 stays steady. A read in a marked sector returns status with bit 2 inverting. A read in an unmarked sector returns array data.
- R4: A read strobe gives `rd_valid` high on the next cycle, with the byte on `rd_data`. In the status byte, bits 7, 4, 1 and 0 are always 0.
- R5: A program command stores old AND new data at the address. The device stays busy for PROG_CYC cycles, then idle reads return array data.
- R6: A program that would turn a 0 bit into a 1 keeps the device busy for PULSE_LIMIT cycles. It then raises status bit 5 and leaves the array byte unchanged.
- R7: After a fault, a reset command returns the device to idle. If the fault came from a program made during suspend, the device returns to suspend instead. A reset command issued while the device is busy and not faulted is ignored.
- R8: A sector erase command opens an acceptance window of WIN_CYC cycles, during which status bit 3 reads 0. Each further sector erase command in the window marks its sector and restarts the full window.
- R9: When the window expires, erase begins and bit 3 reads 1. Every command except suspend is then ignored until the erase ends. At the end, all marked sectors read 0xFF and all other sectors keep their data.
- R10: A chip erase marks every sector and starts erasing at once, with no window, so bit 3 reads 1 from the first status read.
- R11: Resume continues a suspended erase to completion. A program issued during suspend completes and then returns the device to suspend.
- R12: After reset, the device is idle, every array byte reads 0xFF and `rd_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_prog | input | 1 | Program command pulse |
| cmd_sect_erase | input | 1 | Sector erase command pulse; the sector is the top bits of cmd_addr |
| cmd_chip_erase | input | 1 | Chip erase command pulse |
| cmd_suspend | input | 1 | Erase suspend pulse |
| cmd_resume | input | 1 | Erase resume pulse |
| cmd_reset | input | 1 | Reset command pulse (clears a fault) |
| cmd_addr | input | ADDR_W | Command address |
| cmd_data | input | 8 | Program data |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | ADDR_W | Read address |
| rd_data | output | 8 | Status or array byte |
| rd_valid | output | 1 | rd_data valid, one cycle after rd_en |

## Verification
The hardest state to reach is a fault raised by a program issued during erase suspend. It needs a finished window, a running erase, a suspend, and an infeasible program, all before the erase counter runs out. The stimulus first programs a few bytes, then marks two sectors a few cycles apart so that the window restart can be observed. It suspends well inside the erase time, runs one good program and one bad program, and checks that the reset command lands back in suspend, where marked-sector reads still report status.

// File: rtl/flash_stat_pkg.sv
package flash_stat_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROG,
        ST_EWIN,
        ST_ERASE,
        ST_SUSP,
        ST_SPROG,
        ST_FAULT
    } op_state_t;

    typedef struct packed {
        logic tog_mode;
        logic timeout;
        logic erase_on;
        logic tog_sect;
    } status_t;

    function automatic logic [7:0] pack_status(status_t s);
        return {1'b0, s.tog_mode, s.timeout, 1'b0, s.erase_on, s.tog_sect, 2'b00};
    endfunction

    function automatic logic is_busy(op_state_t s);
        return (s == ST_PROG) || (s == ST_EWIN) || (s == ST_ERASE) ||
               (s == ST_SPROG) || (s == ST_FAULT);
    endfunction

    function automatic logic erase_started(op_state_t s);
        return (s == ST_ERASE) || (s == ST_SUSP) || (s == ST_SPROG);
    endfunction

endpackage

// File: rtl/fs_array.sv
module fs_array #(
    parameter int ADDR_W = 6,
    parameter int NSECT  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [7:0]        wr_data,
    input  logic              erase_en,
    input  logic [NSECT-1:0]  erase_mask,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_word,
    input  logic [ADDR_W-1:0] chk_addr,
    output logic [7:0]        chk_word
);
    localparam int DEPTH     = 1 << ADDR_W;
    localparam int SECT_SIZE = DEPTH / NSECT;

    logic [7:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
        end else if (erase_en) begin
            for (int i = 0; i < DEPTH; i++)
                if (erase_mask[i / SECT_SIZE]) mem[i] <= 8'hFF;
        end else if (wr_en) begin
            mem[wr_addr] <= mem[wr_addr] & wr_data;
        end
    end

    assign rd_word  = mem[rd_addr];
    assign chk_word = mem[chk_addr];

endmodule

// File: rtl/fs_seq.sv
module fs_seq
    import flash_stat_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int NSECT       = 8,
    parameter int WIN_CYC     = 16,
    parameter int PROG_CYC    = 4,
    parameter int PULSE_LIMIT = 20,
    parameter int ERASE_CYC   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_prog,
    input  logic              cmd_sect_erase,
    input  logic              cmd_chip_erase,
    input  logic              cmd_suspend,
    input  logic              cmd_resume,
    input  logic              cmd_reset,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic [7:0]        chk_word,
    output op_state_t         state,
    output logic [NSECT-1:0]  sel,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              erase_en
);
    localparam int SECT_W = $clog2(NSECT);
    localparam int PCW    = $clog2(PULSE_LIMIT + 1);
    localparam int EMAX   = (WIN_CYC > ERASE_CYC) ? WIN_CYC : ERASE_CYC;
    localparam int ECW    = $clog2(EMAX + 1);
    localparam logic [PCW-1:0] P_DONE = PCW'(PROG_CYC - 1);
    localparam logic [PCW-1:0] P_FAIL = PCW'(PULSE_LIMIT - 1);
    localparam logic [ECW-1:0] W_DONE = ECW'(WIN_CYC - 1);
    localparam logic [ECW-1:0] E_DONE = ECW'(ERASE_CYC - 1);

    logic [ECW-1:0]    ecnt;
    logic [PCW-1:0]    pcnt;
    logic              p_bad;
    logic              f_susp;
    logic [NSECT-1:0]  sect_bit;
    logic              new_bad;
    logic              in_prog;

    assign sect_bit = NSECT'(1) << cmd_addr[ADDR_W-1 -: SECT_W];
    assign new_bad  = |(cmd_data & ~chk_word);
    assign in_prog  = (state == ST_PROG) || (state == ST_SPROG);
    assign wr_en    = in_prog && !p_bad && (pcnt == P_DONE);
    assign erase_en = (state == ST_ERASE) && !cmd_suspend && (ecnt == E_DONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            sel     <= '0;
            ecnt    <= '0;
            pcnt    <= '0;
            wr_addr <= '0;
            wr_data <= '0;
            p_bad   <= 1'b0;
            f_susp  <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cmd_prog) begin
                        wr_addr <= cmd_addr;
                        wr_data <= cmd_data;
                        p_bad   <= new_bad;
                        pcnt    <= '0;
                        state   <= ST_PROG;
                    end else if (cmd_sect_erase) begin
                        sel   <= sel | sect_bit;
                        ecnt  <= '0;
                        state <= ST_EWIN;
                    end else if (cmd_chip_erase) begin
                        sel   <= '1;
                        ecnt  <= '0;
                        state <= ST_ERASE;
                    end
                end
                ST_PROG, ST_SPROG: begin
                    if (!p_bad && pcnt == P_DONE) begin
                        state <= (state == ST_SPROG) ? ST_SUSP : ST_IDLE;
                    end else if (p_bad && pcnt == P_FAIL) begin
                        f_susp <= (state == ST_SPROG);
                        state  <= ST_FAULT;
                    end else begin
                        pcnt <= pcnt + 1'b1;
                    end
                end
                ST_EWIN: begin
                    if (cmd_sect_erase) begin
                        sel  <= sel | sect_bit;
                        ecnt <= '0;
                    end else if (ecnt == W_DONE) begin
                        ecnt  <= '0;
                        state <= ST_ERASE;
                    end else begin
                        ecnt <= ecnt + 1'b1;
                    end
                end
                ST_ERASE: begin
                    if (cmd_suspend) begin
                        state <= ST_SUSP;
                    end else if (ecnt == E_DONE) begin
                        sel   <= '0;
                        ecnt  <= '0;
                        state <= ST_IDLE;
                    end else begin
                        ecnt <= ecnt + 1'b1;
                    end
                end
                ST_SUSP: begin
                    if (cmd_resume) begin
                        state <= ST_ERASE;
                    end else if (cmd_prog) begin
                        wr_addr <= cmd_addr;
                        wr_data <= cmd_data;
                        p_bad   <= new_bad;
                        pcnt    <= '0;
                        state   <= ST_SPROG;
                    end
                end
                ST_FAULT: begin
                    if (cmd_reset) state <= f_susp ? ST_SUSP : ST_IDLE;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8
    ewin_restart_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_EWIN && cmd_sect_erase) |=> (state == ST_EWIN && ecnt == '0));

    // R9
    erase_lock_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_ERASE && !cmd_suspend) |=> (state == ST_ERASE || state == ST_IDLE));

    // R6
    no_false_fault_chk: assert property (@(posedge clk) disable iff (rst)
        (in_prog && !p_bad) |=> (state != ST_FAULT));

    // R7
    fault_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (state == ST_FAULT && !cmd_reset) |=> (state == ST_FAULT));

endmodule

// File: rtl/fs_status.sv
module fs_status
    import flash_stat_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int NSECT  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  op_state_t         state,
    input  logic [NSECT-1:0]  sel,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        arr_word,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    localparam int SECT_W = $clog2(NSECT);

    logic    t6, t2, hit, show_status;
    status_t st;

    assign hit         = sel[rd_addr[ADDR_W-1 -: SECT_W]];
    assign show_status = (state != ST_IDLE) && !(state == ST_SUSP && !hit);

    always_comb begin
        st.tog_mode = t6;
        st.timeout  = (state == ST_FAULT);
        st.erase_on = erase_started(state);
        st.tog_sect = t2;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            t6       <= 1'b0;
            t2       <= 1'b0;
            rd_data  <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) begin
                rd_data <= show_status ? pack_status(st) : arr_word;
                if (is_busy(state)) t6 <= ~t6;
                if (hit && state != ST_IDLE) t2 <= ~t2;
            end
        end
    end

    // R4
    rd_valid_chk: assert property (@(posedge clk) disable iff (rst)
        rd_en |=> rd_valid);

    // R4
    rd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !rd_en |=> !rd_valid);

endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen
    import flash_stat_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int NSECT       = 8,
    parameter int WIN_CYC     = 16,
    parameter int PROG_CYC    = 4,
    parameter int PULSE_LIMIT = 20,
    parameter int ERASE_CYC   = 64
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_prog,
    input  logic              cmd_sect_erase,
    input  logic              cmd_chip_erase,
    input  logic              cmd_suspend,
    input  logic              cmd_resume,
    input  logic              cmd_reset,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic [7:0]        cmd_data,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [7:0]        rd_data,
    output logic              rd_valid
);
    op_state_t         state;
    logic [NSECT-1:0]  sel;
    logic              wr_en, erase_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [7:0]        wr_data, arr_word, chk_word;

    fs_seq #(
        .ADDR_W(ADDR_W), .NSECT(NSECT), .WIN_CYC(WIN_CYC),
        .PROG_CYC(PROG_CYC), .PULSE_LIMIT(PULSE_LIMIT), .ERASE_CYC(ERASE_CYC)
    ) u_seq (
        .clk(clk), .rst(rst),
        .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase),
        .cmd_chip_erase(cmd_chip_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_reset(cmd_reset),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .chk_word(chk_word),
        .state(state), .sel(sel), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .erase_en(erase_en)
    );

    fs_array #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_array (
        .clk(clk), .rst(rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .erase_en(erase_en), .erase_mask(sel),
        .rd_addr(rd_addr), .rd_word(arr_word),
        .chk_addr(cmd_addr), .chk_word(chk_word)
    );

    fs_status #(.ADDR_W(ADDR_W), .NSECT(NSECT)) u_status (
        .clk(clk), .rst(rst), .state(state), .sel(sel),
        .rd_en(rd_en), .rd_addr(rd_addr), .arr_word(arr_word),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

endmodule

// File: tb/flash_status_gen_bench.sv
module flash_status_gen_bench;
    localparam int ADDR_W = 6;
    localparam int PROG_CYC = 4;
    localparam int PULSE_LIMIT = 20;

    // {addr, program data, expected readback}
    localparam logic [21:0] VEC [7] = '{
        {6'h01, 8'hA5, 8'hA5},
        {6'h02, 8'h3C, 8'h3C},
        {6'h01, 8'h25, 8'h25},
        {6'h09, 8'h00, 8'h00},
        {6'h3F, 8'h7E, 8'h7E},
        {6'h10, 8'hF0, 8'hF0},
        {6'h1A, 8'h11, 8'h11}
    };

    logic clk = 0, rst = 1;
    logic cmd_prog = 0, cmd_sect_erase = 0, cmd_chip_erase = 0;
    logic cmd_suspend = 0, cmd_resume = 0, cmd_reset = 0;
    logic [ADDR_W-1:0] cmd_addr = '0, rd_addr = '0;
    logic [7:0] cmd_data = '0, rd_data;
    logic rd_en = 0, rd_valid;
    int nchk = 0, nerr = 0;
    bit done = 0;

    always #2 clk = ~clk;

    flash_status_gen u_flash_status_gen (
        .clk(clk), .rst(rst), .cmd_prog(cmd_prog), .cmd_sect_erase(cmd_sect_erase),
        .cmd_chip_erase(cmd_chip_erase), .cmd_suspend(cmd_suspend),
        .cmd_resume(cmd_resume), .cmd_reset(cmd_reset), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // kind: 0 program, 1 sector erase, 2 chip erase, 3 suspend, 4 resume, 5 reset
    task automatic cmd(input int kind, input logic [ADDR_W-1:0] a, input logic [7:0] d);
        cmd_addr = a; cmd_data = d;
        cmd_prog = (kind == 0); cmd_sect_erase = (kind == 1); cmd_chip_erase = (kind == 2);
        cmd_suspend = (kind == 3); cmd_resume = (kind == 4); cmd_reset = (kind == 5);
        @(negedge clk);
        cmd_prog = 0; cmd_sect_erase = 0; cmd_chip_erase = 0;
        cmd_suspend = 0; cmd_resume = 0; cmd_reset = 0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [7:0] d);
        rd_en = 1; rd_addr = a;
        @(negedge clk);
        rd_en = 0;
        d = rd_data;
        nchk++;
        if (rd_valid !== 1'b1) begin
            nerr++;
            $display("FAIL R4: rd_valid actual %b expected 1", rd_valid);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
            $finish;
        end
    end

    initial begin
        logic [7:0] s1, s2, v;
        logic [ADDR_W-1:0] a;
        logic [7:0] d, e;
        wait_cyc(3);
        rst = 0;
        wait_cyc(1);
        check("R12 rd_valid", {7'd0, rd_valid}, 8'h00);
        rd(6'h2A, v);
        check("R12 erased", v, 8'hFF);

        for (int i = 0; i < 7; i++) begin
            {a, d, e} = VEC[i];
            cmd(0, a, d);
            rd(a, s1);
            rd(6'h33, s2);
            check("R1 bit6 flips", {7'd0, s1[6] ^ s2[6]}, 8'h01);
            check("R4 zero bits", s1 & 8'hBB, 8'h00);
            wait_cyc(PROG_CYC + 2);
            rd(a, v);
            check("R5 program", v, e);
        end

        // fault on 0->1 program; reset ignored while not faulted
        cmd(0, 6'h02, 8'hFF);
        rd(6'h02, s1);
        check("R6 no early timeout", {7'd0, s1[5]}, 8'h00);
        cmd(5, 6'h00, 8'h00);
        wait_cyc(PULSE_LIMIT + 4);
        rd(6'h02, s1);
        rd(6'h02, s2);
        check("R6 timeout set", {7'd0, s1[5]}, 8'h01);
        check("R7 reset ignored while busy", {7'd0, s2[5]}, 8'h01);
        check("R1 bit6 in fault", {7'd0, s1[6] ^ s2[6]}, 8'h01);
        cmd(5, 6'h00, 8'h00);
        rd(6'h02, v);
        check("R7 back to idle, R6 array kept", v, 8'h3C);

        // sector erase window with restart
        cmd(1, 6'h18, 8'h00);
        rd(6'h18, s1);
        check("R8 window bit3", {7'd0, s1[3]}, 8'h00);
        wait_cyc(8);
        cmd(1, 6'h20, 8'h00);
        wait_cyc(10);
        rd(6'h18, s1);
        check("R8 window restarted", {7'd0, s1[3]}, 8'h00);
        wait_cyc(20);
        rd(6'h1A, s1);
        rd(6'h1A, s2);
        check("R9 erase begun bit3", {7'd0, s1[3]}, 8'h01);
        check("R2 bit2 flips in marked sector", {7'd0, s1[2] ^ s2[2]}, 8'h01);
        rd(6'h01, s1);
        rd(6'h01, s2);
        check("R2 bit2 steady elsewhere", {7'd0, s1[2] ^ s2[2]}, 8'h00);
        check("R1 bit6 any address", {7'd0, s1[6] ^ s2[6]}, 8'h01);
        cmd(0, 6'h05, 8'h00);
        cmd(2, 6'h00, 8'h00);

        // suspend
        cmd(3, 6'h00, 8'h00);
        rd(6'h01, v);
        check("R3 unmarked reads array", v, 8'h25);
        rd(6'h1A, s1);
        rd(6'h1A, s2);
        check("R3 bit6 steady", {7'd0, s1[6] ^ s2[6]}, 8'h00);
        check("R3 bit2 flips", {7'd0, s1[2] ^ s2[2]}, 8'h01);
        check("R3 bit3 in suspend", {7'd0, s1[3]}, 8'h01);
        cmd(0, 6'h01, 8'h05);
        wait_cyc(PROG_CYC + 2);
        rd(6'h01, v);
        check("R11 program in suspend", v, 8'h05);
        cmd(0, 6'h01, 8'h0F);
        wait_cyc(PULSE_LIMIT + 4);
        rd(6'h1A, s1);
        check("R6 fault in suspend", {7'd0, s1[5]}, 8'h01);
        cmd(5, 6'h00, 8'h00);
        rd(6'h1A, s1);
        check("R7 back to suspend status", s1 & 8'hA8, 8'h08);
        rd(6'h01, v);
        check("R7 suspend array read", v, 8'h05);
        cmd(4, 6'h00, 8'h00);
        wait_cyc(80);
        rd(6'h1A, v);
        check("R9 marked sector erased", v, 8'hFF);
        rd(6'h20, v);
        check("R9 second sector erased", v, 8'hFF);
        rd(6'h05, v);
        check("R9 program during erase ignored", v, 8'hFF);
        rd(6'h09, v);
        check("R9 unmarked sector kept", v, 8'h00);
        rd(6'h3F, v);
        check("R9 chip erase ignored", v, 8'h7E);

        // chip erase
        cmd(2, 6'h00, 8'h00);
        rd(6'h09, s1);
        rd(6'h09, s2);
        check("R10 no window", {7'd0, s1[3]}, 8'h01);
        check("R10 all sectors marked", {7'd0, s1[2] ^ s2[2]}, 8'h01);
        wait_cyc(80);
        rd(6'h09, v);
        check("R10 chip erased", v, 8'hFF);
        rd(6'h3F, v);
        check("R10 chip erased top", v, 8'hFF);

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
        $finish;
    end
endmodule